// File: doc/BRIEF.md
# Predicated Half-Precision Vector Fused Multiply-Subtract Unit

This unit runs one predicated vector instruction. In each active 16-bit lane it takes the product of the first and second source elements, subtracts the addend element, and rounds the result once, to nearest with ties to even. The finished vector replaces the addend operand, which is also the destination. Lanes whose predicate bit is clear keep their old addend value. The register fields of the instruction word are decoded elsewhere. The unit itself receives the three operand vectors and the governing predicate value, together with the raw 32-bit word. It checks the fixed opcode bits and the element-size field in that word.

A request is accepted through a valid/ready handshake. The control is a three-state machine. IDLE waits with `in_ready` high. On the transition called *accept*, a well-formed half-precision request moves to RUN. On the transition called *reject-fast*, a reserved or unsupported encoding moves straight to DONE. RUN computes one lane per clock through a single fused datapath. Each *lane-advance* stays in RUN, and the *last-lane* transition moves to DONE. DONE raises `done` for one cycle and then takes the *release* transition back to IDLE. The result and the two flags hold their values until the next request is accepted.

The arithmetic is exact up to the single final rounding. The product and the negated addend are summed in a wide fixed-point accumulator, and only then is the sum normalised and rounded. Subnormal inputs and outputs keep their full precision.

Top module: `fms_unit`

## Requirements
- R1: A word is well-formed only if bits 31:24 equal 01100101, bit 21 is 1 and bits 15:13 equal 011. A word that fails this check, or that has 00 in the size field (bits 23:22), raises `undef` with `unsup` low. `result` then equals the addend vector unchanged, and `done` rises in the cycle after the accepting edge.
- R2: A well-formed word with size field 10 or 11 raises `unsup` with `undef` low. It returns the addend unchanged, on the same one-cycle path as R1.
- R3: Size field 01 selects 16-bit lanes. There are VLEN/16 lanes, and lane e occupies `result[16e+15:16e]`. `done` rises VLEN/16 edges after the accepting edge.
- R4: Lane e is active exactly when predicate bit 2e is set. Odd predicate bits have no effect. An inactive lane returns its original addend element.
- R5: An active lane returns (first × second) − addend with one rounding to nearest-even. Subnormal operands and results are exact rather than flushed. Only the addend's sign is flipped, never the product's.
- R6: If any operand is a NaN, the lane returns 16'h7E00. It also returns 16'h7E00 for infinity × zero, and when an infinite product meets an infinite addend whose negation has the opposite sign.
- R7: An exactly zero sum is +0, except when the product and the negated addend are both −0, in which case it is −0.
- R8: Overflow returns a signed infinity (16'h7C00 or 16'hFC00). An infinite product, or an infinite addend paired with a finite product, yields the matching signed infinity.
- R9: After reset, `in_ready` is 1 and `done`, `undef`, `unsup` and `result` are 0. `in_ready` is high only in IDLE, and a request offered while busy is not taken. `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle; request taken on this edge when valid |
| instr | input | 32 | Raw instruction word |
| vec_n | input | VLEN | First multiplicand vector |
| vec_m | input | VLEN | Second multiplicand vector |
| vec_da | input | VLEN | Addend vector, also the destination's old value |
| pred | input | VLEN/8 | Governing predicate, one bit per byte |
| result | output | VLEN | New destination vector, held after done |
| done | output | 1 | One-cycle completion strobe |
| undef | output | 1 | Reserved or non-matching encoding |
| unsup | output | 1 | Valid encoding with an element size other than 16 bits |

## Verification
The bench builds the unit with VLEN = 128. That gives eight lanes, a 16-bit predicate, and an eight-edge RUN phase. At this size, a single request can mix active and inactive lanes with all four corner classes: NaN, infinity, signed zero and subnormal. The odd predicate bits are present and can be driven without effect. A behavioural reference computes every lane's exact product minus addend in wide integers. It then picks the nearest encoding by binary search over the ordered half-precision values. The reference also predicts `in_ready` and `done` cycle by cycle, so repeated requests offered while the unit is busy are covered as well.

// File: rtl/fms_pkg.sv
package fms_pkg;

    // Half-precision format
    localparam int HW       = 16;
    localparam int MANT     = 10;
    localparam int BIAS     = 15;
    localparam int EXPW     = 5;

    // Fixed-point accumulator: LSB weight is the product of two minimum subnormals
    localparam int FRAC     = 2 * (BIAS - 1 + MANT);   // 48
    localparam int SUB_LSB  = FRAC - (BIAS - 1 + MANT); // 24: weight of the smallest subnormal
    localparam int NORM_MIN = SUB_LSB + MANT;          // leading-one position of the smallest normal
    localparam int ACC_W    = 82;
    localparam int NOPS     = 3;

    // Encoding fields
    localparam logic [7:0]    OPC_HI  = 8'b0110_0101;
    localparam logic [2:0]    OPC_MID = 3'b011;
    localparam logic [1:0]    SZ_RSV  = 2'b00;
    localparam logic [1:0]    SZ_HALF = 2'b01;
    localparam logic [HW-1:0] QNAN    = 16'h7E00;
    localparam int            INF_ENC = 'h7C00;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RUN,
        S_DONE
    } fsm_t;

    typedef struct packed {
        logic            sign;
        logic [EXPW-1:0] ex_eff;
        logic [MANT:0]   sig;
        logic            is_zero;
        logic            is_inf;
        logic            is_nan;
    } hunp_t;

endpackage

// File: rtl/fms_decode.sv
module fms_decode
    import fms_pkg::*;
(
    input  logic [31:0] iw,
    output logic        undef_o,
    output logic        unsup_o
);

    logic        match;
    logic [1:0]  size_f;
    logic [12:0] unused_reg_fields;

    assign unused_reg_fields = {iw[20:16], iw[12:10], iw[9:5]};

    always_comb begin
        size_f  = iw[23:22];
        match   = (iw[31:24] == OPC_HI) && iw[21] && (iw[15:13] == OPC_MID);
        undef_o = !match || (size_f == SZ_RSV);
        unsup_o = !undef_o && (size_f != SZ_HALF);
    end

endmodule

// File: rtl/fms_unpack.sv
module fms_unpack
    import fms_pkg::*;
(
    input  logic [HW-1:0] h,
    output hunp_t         u
);

    logic [EXPW-1:0] ex;
    logic [MANT-1:0] fr;

    always_comb begin
        ex        = h[HW-2:MANT];
        fr        = h[MANT-1:0];
        u.sign    = h[HW-1];
        u.is_nan  = (&ex) && (fr != '0);
        u.is_inf  = (&ex) && (fr == '0);
        u.is_zero = (ex == '0) && (fr == '0);
        u.ex_eff  = (ex == '0) ? EXPW'(1) : ex;
        u.sig     = {(ex != '0), fr};
    end

endmodule

// File: rtl/fms_hfma.sv
module fms_hfma
    import fms_pkg::*;
(
    input  logic [HW-1:0] a,
    input  logic [HW-1:0] b,
    input  logic [HW-1:0] c,
    output logic [HW-1:0] r
);

    logic [HW-1:0]    op [NOPS];
    hunp_t            up [NOPS];

    assign op[0] = a;
    assign op[1] = b;
    assign op[2] = c;

    for (genvar g = 0; g < NOPS; g++) begin : g_unp
        fms_unpack u_unp (.h(op[g]), .u(up[g]));
    end

    logic              unused_czero;
    assign unused_czero = up[2].is_zero;

    logic [2*MANT+1:0] pm;
    logic [6:0]        psh, csh;
    logic [ACC_W-1:0]  pmag, cmag, mag;
    logic              sp, sc, sgn;
    logic              nan, pinf, guard, sticky, rnd;
    logic [11:0]       q;
    logic [12:0]       qr;
    int                lead, lsb, encw;

    always_comb begin
        sp   = up[0].sign ^ up[1].sign;
        sc   = ~up[2].sign;                       // only the addend is negated
        pm   = (2*MANT+2)'(up[0].sig) * (2*MANT+2)'(up[1].sig);
        psh  = 7'(up[0].ex_eff) + 7'(up[1].ex_eff) - 7'd2;
        csh  = 7'(up[2].ex_eff) + 7'(SUB_LSB - 1);
        pmag = ACC_W'(pm) << psh;
        cmag = ACC_W'(up[2].sig) << csh;

        if (sp == sc) begin
            mag = pmag + cmag;
            sgn = sp;
        end else if (pmag >= cmag) begin
            mag = pmag - cmag;
            sgn = sp;
        end else begin
            mag = cmag - pmag;
            sgn = sc;
        end
        if (mag == '0) sgn = sp & sc;

        lead = 0;
        for (int i = 0; i < ACC_W; i++) begin
            if (mag[7'(i)]) lead = i;
        end
        lsb    = (lead >= NORM_MIN) ? lead - MANT : SUB_LSB;
        q      = 12'(mag >> lsb);
        guard  = 1'(mag >> (lsb - 1));
        sticky = |(mag & ((ACC_W'(1) << (lsb - 1)) - ACC_W'(1)));
        rnd    = guard & (sticky | q[0]);
        qr     = 13'(q) + 13'(rnd);
        encw   = ((lsb - SUB_LSB) << MANT) + int'(qr);

        pinf = up[0].is_inf | up[1].is_inf;
        nan  = up[0].is_nan | up[1].is_nan | up[2].is_nan
             | (up[0].is_inf & up[1].is_zero) | (up[0].is_zero & up[1].is_inf)
             | (pinf & up[2].is_inf & (sp != sc));

        if (nan)               r = QNAN;
        else if (pinf)         r = {sp, 15'h7C00};
        else if (up[2].is_inf) r = {sc, 15'h7C00};
        else if (encw >= INF_ENC) r = {sgn, 15'h7C00};
        else                   r = {sgn, encw[14:0]};
    end

    // R6
    always_comb begin
        if (up[0].is_nan || up[1].is_nan || up[2].is_nan) begin
            nan_prop_chk: assert (r == QNAN);
        end
    end

endmodule

// File: rtl/fms_unit.sv
module fms_unit
    import fms_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       instr,
    input  logic [VLEN-1:0]   vec_n,
    input  logic [VLEN-1:0]   vec_m,
    input  logic [VLEN-1:0]   vec_da,
    input  logic [VLEN/8-1:0] pred,
    output logic [VLEN-1:0]   result,
    output logic              done,
    output logic              undef,
    output logic              unsup
);

    localparam int LANES = VLEN / HW;
    localparam int LW    = $clog2(LANES);
    localparam int PSTEP = HW / 8;

    fsm_t             st_q, st_nx;
    logic [LW-1:0]    lane_q;
    logic [HW-1:0]    n_l [LANES];
    logic [HW-1:0]    m_l [LANES];
    logic [HW-1:0]    da_l [LANES];
    logic [HW-1:0]    n_q [LANES];
    logic [HW-1:0]    m_q [LANES];
    logic [HW-1:0]    res_q [LANES];
    logic [LANES-1:0] act_l, act_q;
    logic             undef_q, unsup_q;
    logic             dec_undef, dec_unsup;
    logic             take, last;
    logic [HW-1:0]    fma_r;
    logic             unused_pred_bits;

    assign unused_pred_bits = ^pred;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign n_l[g]                = vec_n[g*HW +: HW];
        assign m_l[g]                = vec_m[g*HW +: HW];
        assign da_l[g]               = vec_da[g*HW +: HW];
        assign act_l[g]              = pred[g*PSTEP];
        assign result[g*HW +: HW]    = res_q[g];
    end

    fms_decode u_dec (
        .iw      (instr),
        .undef_o (dec_undef),
        .unsup_o (dec_unsup)
    );

    fms_hfma u_fma (
        .a (n_q[lane_q]),
        .b (m_q[lane_q]),
        .c (res_q[lane_q]),
        .r (fma_r)
    );

    assign take = in_valid && (st_q == S_IDLE);
    assign last = (lane_q == LW'(LANES - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_nx;
    end

    // Transitions: accept, reject-fast, lane-advance, last-lane, release
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            S_IDLE: if (in_valid) st_nx = (dec_undef || dec_unsup) ? S_DONE : S_RUN;
            S_RUN:  if (last)     st_nx = S_DONE;
            S_DONE:               st_nx = S_IDLE;
            default:              st_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready = (st_q == S_IDLE);
        done     = (st_q == S_DONE);
        undef    = undef_q;
        unsup    = unsup_q;
    end

    // Lane datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q  <= '0;
            n_q     <= '{default: '0};
            m_q     <= '{default: '0};
            res_q   <= '{default: '0};
            act_q   <= '0;
            undef_q <= 1'b0;
            unsup_q <= 1'b0;
        end else if (take) begin
            n_q     <= n_l;
            m_q     <= m_l;
            res_q   <= da_l;
            act_q   <= act_l;
            undef_q <= dec_undef;
            unsup_q <= dec_unsup;
            lane_q  <= '0;
        end else if (st_q == S_RUN) begin
            if (act_q[lane_q]) res_q[lane_q] <= fma_r;
            lane_q <= lane_q + LW'(1);
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R1
    bad_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (undef || unsup)) |-> (result == $past(vec_da)));

    // R3
    half_no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !dec_undef && !dec_unsup) |=> !done);

endmodule

// File: tb/tb_fms_unit.sv
module tb_fms_unit;

    localparam int CLK_P = 10;
    localparam int VLEN  = 128;
    localparam int LANES = VLEN / 16;
    localparam int PW    = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [31:0]     instr = '0;
    logic [VLEN-1:0] vec_n = '0, vec_m = '0, vec_da = '0;
    logic [PW-1:0]   pred = '0;
    logic [VLEN-1:0] result;
    logic            done, undef, unsup;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fms_unit #(.VLEN(VLEN)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .instr(instr), .vec_n(vec_n), .vec_m(vec_m), .vec_da(vec_da), .pred(pred),
        .result(result), .done(done), .undef(undef), .unsup(unsup)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [127:0] hmag(input logic [15:0] h);
        int e;
        e = int'(h[14:10]);
        if (e == 0) return 128'(h[9:0]) << 24;
        return 128'({1'b1, h[9:0]}) << (e + 23);
    endfunction

    function automatic logic [15:0] ref_lane(input logic [15:0] a, input logic [15:0] b,
                                             input logic [15:0] c);
        bit an, bn, cn, ai, bi, ci, az, bz, ps, cs, s, pinf;
        logic [127:0] pm, cm, m, d1, d2;
        int lo, hi, mid, pick;
        an = (a[14:10] == 5'h1F) && (a[9:0] != 0);
        bn = (b[14:10] == 5'h1F) && (b[9:0] != 0);
        cn = (c[14:10] == 5'h1F) && (c[9:0] != 0);
        ai = (a[14:0] == 15'h7C00);
        bi = (b[14:0] == 15'h7C00);
        ci = (c[14:0] == 15'h7C00);
        az = (a[14:0] == 0);
        bz = (b[14:0] == 0);
        ps = a[15] ^ b[15];
        cs = !c[15];
        pinf = ai || bi;
        if (an || bn || cn) return 16'h7E00;
        if ((ai && bz) || (az && bi)) return 16'h7E00;
        if (pinf && ci && (ps != cs)) return 16'h7E00;
        if (pinf) return {ps, 15'h7C00};
        if (ci) return {cs, 15'h7C00};
        pm = (hmag(a) * hmag(b)) >> 48;
        cm = hmag(c);
        if (ps == cs) begin m = pm + cm; s = ps; end
        else if (pm > cm) begin m = pm - cm; s = ps; end
        else if (cm > pm) begin m = cm - pm; s = cs; end
        else begin m = 0; s = 1'b0; end
        if (m >= hmag(16'h7C00)) return {s, 15'h7C00};
        lo = 0;
        hi = 'h7BFF;
        while (lo < hi) begin
            mid = (lo + hi + 1) / 2;
            if (hmag(16'(mid)) <= m) lo = mid;
            else hi = mid - 1;
        end
        d1 = m - hmag(16'(lo));
        d2 = hmag(16'(lo + 1)) - m;
        pick = lo;
        if (d1 != 0 && ((d2 < d1) || (d2 == d1 && (lo % 2) == 1))) pick = lo + 1;
        return {s, 15'(pick)};
    endfunction

    function automatic logic [15:0] lane_of(input logic [VLEN-1:0] v, input int e);
        return 16'(v >> (16 * e));
    endfunction

    // Cycle model of the handshake and expected results
    bit              exp_ready = 1'b1, exp_done = 1'b0;
    int              rem = 0;
    logic [VLEN-1:0] exp_res = '0;
    bit              exp_undef = 1'b0, exp_unsup = 1'b0;
    string           exp_tag = "R9";

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_ready = 1'b1; exp_done = 1'b0; rem = 0;
        end else if (exp_done) begin
            exp_done = 1'b0; exp_ready = 1'b1;
        end else if (exp_ready) begin
            if (in_valid) begin
                bit ok;
                ok = (instr[31:24] == 8'h65) && instr[21] && (instr[15:13] == 3'b011);
                exp_undef = !ok || (instr[23:22] == 2'b00);
                exp_unsup = !exp_undef && (instr[23:22] != 2'b01);
                exp_res   = vec_da;
                exp_ready = 1'b0;
                if (exp_undef || exp_unsup) begin
                    rem = 0; exp_done = 1'b1;
                end else begin
                    for (int e = 0; e < LANES; e++) begin
                        if (1'(pred >> (2 * e))) begin
                            logic [15:0] rv;
                            rv = ref_lane(lane_of(vec_n, e), lane_of(vec_m, e), lane_of(vec_da, e));
                            exp_res = (exp_res & ~(VLEN'(16'hFFFF) << (16 * e)))
                                    | (VLEN'(rv) << (16 * e));
                        end
                    end
                    rem = LANES;
                end
            end
        end else begin
            rem--;
            if (rem == 0) exp_done = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (in_ready !== exp_ready) begin
                errors++;
                $display("FAIL R9 in_ready: actual %0b expected %0b at %0t", in_ready, exp_ready, $time);
            end
            checks++;
            if (done !== exp_done) begin
                errors++;
                $display("FAIL R3 done timing: actual %0b expected %0b at %0t", done, exp_done, $time);
            end
            if (exp_done) begin
                checks++;
                if (result !== exp_res) begin
                    errors++;
                    $display("FAIL %s result: actual %h expected %h", exp_tag, result, exp_res);
                end
                checks++;
                if (undef !== exp_undef || unsup !== exp_unsup) begin
                    errors++;
                    $display("FAIL %s flags: actual undef=%0b unsup=%0b expected undef=%0b unsup=%0b",
                             exp_tag, undef, unsup, exp_undef, exp_unsup);
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] mk(input logic [1:0] sz);
        return {8'b0110_0101, sz, 1'b1, 5'd3, 3'b011, 3'd2, 5'd7, 5'd9};
    endfunction

    task automatic put(input int e, input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
        vec_n  = (vec_n  & ~(VLEN'(16'hFFFF) << (16 * e))) | (VLEN'(a) << (16 * e));
        vec_m  = (vec_m  & ~(VLEN'(16'hFFFF) << (16 * e))) | (VLEN'(b) << (16 * e));
        vec_da = (vec_da & ~(VLEN'(16'hFFFF) << (16 * e))) | (VLEN'(c) << (16 * e));
    endtask

    task automatic fill_random();
        for (int e = 0; e < LANES; e++)
            put(e, 16'($urandom), 16'($urandom), 16'($urandom));
    endtask

    task automatic issue(input string tag, input logic [31:0] iw, input logic [PW-1:0] p);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        exp_tag  = tag;
        instr    = iw;
        pred     = p;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        while (!in_ready) @(negedge clk);
    endtask

    // ---------------- test sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        checks++;
        if (in_ready !== 1'b1 || done !== 1'b0 || undef !== 1'b0 || unsup !== 1'b0 || result !== '0) begin
            errors++;
            $display("FAIL R9 reset: actual ready=%0b done=%0b undef=%0b unsup=%0b result=%h expected 1 0 0 0 0",
                     in_ready, done, undef, unsup, result);
        end

        // R1 reserved size, wrong opcode, bit 21 clear
        fill_random();
        issue("R1", mk(2'b00), '1);
        issue("R1", mk(2'b01) ^ 32'h0100_0000, '1);
        issue("R1", mk(2'b01) & ~32'h0020_0000, '1);
        issue("R1", mk(2'b01) ^ 32'h0000_4000, '1);

        // R2 wider element sizes
        issue("R2", mk(2'b10), '1);
        issue("R2", mk(2'b11), '1);

        // R5 plain arithmetic and cancellation
        put(0, 16'h3C00, 16'h3C00, 16'h3C00);
        put(1, 16'h4000, 16'h4200, 16'h3C00);
        put(2, 16'h3C01, 16'h3C01, 16'h3C00);
        put(3, 16'h3C00, 16'h3C01, 16'h3C00);
        put(4, 16'hC500, 16'h4100, 16'hBC00);
        put(5, 16'h0001, 16'h3800, 16'h0000);
        put(6, 16'h0001, 16'h3A00, 16'h0000);
        put(7, 16'h0400, 16'h3BFF, 16'h0001);
        issue("R5", mk(2'b01), '1);

        // R4 predicate patterns: even bits only, odd bits only, sparse
        fill_random();
        issue("R4", mk(2'b01), 16'h5555);
        issue("R4", mk(2'b01), 16'hAAAA);
        issue("R4", mk(2'b01), 16'h0104);

        // R6 invalid-operation cases
        put(0, 16'h7E01, 16'h3C00, 16'h3C00);
        put(1, 16'h3C00, 16'hFD00, 16'h3C00);
        put(2, 16'h3C00, 16'h3C00, 16'h7C01);
        put(3, 16'h7C00, 16'h0000, 16'h3C00);
        put(4, 16'h8000, 16'hFC00, 16'h3C00);
        put(5, 16'h7C00, 16'h3C00, 16'h7C00);
        put(6, 16'hFC00, 16'h3C00, 16'hFC00);
        put(7, 16'h7C00, 16'h3C00, 16'hFC00);
        issue("R6", mk(2'b01), '1);

        // R7 signed zeros
        put(0, 16'h0000, 16'h0000, 16'h0000);
        put(1, 16'h8000, 16'h0000, 16'h0000);
        put(2, 16'h8000, 16'h0000, 16'h8000);
        put(3, 16'h3C00, 16'h3C00, 16'h3C00);
        put(4, 16'hBC00, 16'h3C00, 16'hBC00);
        put(5, 16'h0001, 16'h0001, 16'h0000);
        put(6, 16'h8001, 16'h0001, 16'h0000);
        put(7, 16'h0000, 16'h8000, 16'h8000);
        issue("R7", mk(2'b01), '1);

        // R8 overflow and infinities
        put(0, 16'h7BFF, 16'h7BFF, 16'h0000);
        put(1, 16'hFBFF, 16'h7BFF, 16'h0000);
        put(2, 16'h3C00, 16'h3C00, 16'h7C00);
        put(3, 16'h3C00, 16'h3C00, 16'hFC00);
        put(4, 16'h7C00, 16'h4000, 16'h3C00);
        put(5, 16'h7BFF, 16'h3C00, 16'hD3FF);
        put(6, 16'h7BFF, 16'h3C00, 16'hCFFF);
        put(7, 16'h5BFF, 16'h5BFF, 16'h7BFF);
        issue("R8", mk(2'b01), '1);

        // R3 and R9: requests held valid while busy are not taken early
        fill_random();
        @(negedge clk);
        exp_tag  = "R3";
        instr    = mk(2'b01);
        pred     = '1;
        in_valid = 1'b1;
        repeat (2 * LANES + 6) @(negedge clk);
        in_valid = 1'b0;
        while (!in_ready) @(negedge clk);

        // R5 random lanes with random predicates
        for (int k = 0; k < 40; k++) begin
            fill_random();
            issue("R5", mk(2'b01), PW'($urandom));
        end

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule